// File: doc/BRIEF.md
# Card Clock Divider with Deferred Update

This block derives a card-side clock from the base clock through a programmable even divider and gates it with an enable and an optional low-power stop. Software writes a divider value and a gating setting into holding registers. Those writes do nothing to the clock until software issues an update request through the command register. The block then copies the held values into its working state and clears the start bit as its acknowledgement.

An update request can ask to wait until the data path is quiet. In that case the block holds the request pending for as long as the data-busy input is high. The block always switches its working state while the card clock is low, so a change never cuts a pulse short. In low-power mode the clock parks low after a fixed number of idle card-clock cycles. It starts again when the bus-request input signals a command or data transfer.

Top module: `cardclk_gen`

## Requirements
- R1: With a working divider value N from 1 to 255, the card clock has a period of 2*N base-clock cycles and a 50% duty cycle.
- R2: With a working divider value of 0, the card clock follows the base clock, giving one card-clock pulse per base-clock cycle.
- R3: After reset, the divider register (word address 0), the gating register (word address 1) and the command register (word address 2) all read 0, and the card clock stays low.
- R4: Register writes are held. The divider register holds an 8-bit value in bits 7:0. The gating register holds the enable in bit 0 and low-power in bit 16. Both read back as written, and neither changes the card clock until an update request is accepted.
- R5: A command-register write with bit 31 (start) and bit 21 (clock update only) both set is an update request. Bit 31 reads 1 until the held values have been applied and then reads 0. A command write that lacks bit 21 is ignored: bit 31 reads 0 and the clock does not change.
- R6: If bit 13 is set in the request, the update is deferred while data_busy is high. Without bit 13, data_busy has no effect on the update.
- R7: A working enable of 0 keeps the card clock low.
- R8: In low-power mode with bus_req low, the clock stops low after 8 card-clock cycles. A bus_req pulse restarts it for another 8 cycles, and a held bus_req keeps it running.
- R9: Register writes made while an update is pending do not alter that update. They take effect at the next update request.
- R10: The working divider and enable change only while the card clock is low, and the divided clock is low in the cycle after a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| data_busy | input | 1 | Data transfer in progress |
| bus_req | input | 1 | Command or data request; wakes the clock in low-power mode |
| card_clk | output | 1 | Gated, divided card clock |

## Verification
The bench writes a new divider and then checks that the clock rate stays the same until the update. A design that applied writes directly would change the rate early. The bench holds data_busy high under a deferred request, looks for the start bit still set and the old rate still running, and writes a new divider while the request waits. A design that ignored the wait, or that sampled the held registers late, would show the new rate too soon or the wrong rate. The bench counts pulses exactly in low-power mode, before and after a wake-up pulse. An off-by-one idle counter, or a wake-up that fails, would give a count other than 8. Other cases are divider 0, odd dividers, and a command write without the update-only bit; designs that got these wrong would show the wrong rate, or a start bit that sets on a plain command.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
  localparam int REG_AW = 2;
  localparam int REG_DW = 32;

  typedef enum logic [REG_AW-1:0] {
    A_DIV = 2'd0,
    A_ENA = 2'd1,
    A_CMD = 2'd2
  } reg_addr_e;

  localparam int START_BIT    = 31;
  localparam int UPD_ONLY_BIT = 21;
  localparam int WAIT_BIT     = 13;
  localparam int EN_BIT       = 0;
  localparam int LP_BIT       = 16;
endpackage

// File: rtl/cardclk_regs.sv
module cardclk_regs
  import cardclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  input  logic              data_busy,
  input  logic              clk_low,
  output logic              apply,
  output logic [DIV_W-1:0]  stg_div,
  output logic              stg_en,
  output logic              stg_lp
);
  logic [DIV_W-1:0]  sh_div_q, sh_div_d;
  logic              sh_en_q, sh_en_d, sh_lp_q, sh_lp_d;
  logic [DIV_W-1:0]  stg_div_d;
  logic              stg_en_d, stg_lp_d;
  logic              pend_q, pend_d, wait_q, wait_d;
  logic [REG_DW-1:0] cmd_q, cmd_d;
  logic              wr_div, wr_ena, req;

  always_comb begin
    wr_div = wr && (addr == A_DIV);
    wr_ena = wr && (addr == A_ENA);
    req    = wr && (addr == A_CMD) && wdata[START_BIT] && wdata[UPD_ONLY_BIT] && !pend_q;
    apply  = pend_q && (!wait_q || !data_busy) && clk_low;

    sh_div_d  = wr_div ? wdata[DIV_W-1:0] : sh_div_q;
    sh_en_d   = wr_ena ? wdata[EN_BIT] : sh_en_q;
    sh_lp_d   = wr_ena ? wdata[LP_BIT] : sh_lp_q;
    stg_div_d = req ? sh_div_q : stg_div;
    stg_en_d  = req ? sh_en_q  : stg_en;
    stg_lp_d  = req ? sh_lp_q  : stg_lp;
    wait_d    = req ? wdata[WAIT_BIT] : wait_q;
    cmd_d     = req ? wdata : cmd_q;
    if (req)        pend_d = 1'b1;
    else if (apply) pend_d = 1'b0;
    else            pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_div_q <= '0;
      sh_en_q  <= 1'b0;
      sh_lp_q  <= 1'b0;
      stg_div  <= '0;
      stg_en   <= 1'b0;
      stg_lp   <= 1'b0;
      pend_q   <= 1'b0;
      wait_q   <= 1'b0;
      cmd_q    <= '0;
    end else begin
      sh_div_q <= sh_div_d;
      sh_en_q  <= sh_en_d;
      sh_lp_q  <= sh_lp_d;
      stg_div  <= stg_div_d;
      stg_en   <= stg_en_d;
      stg_lp   <= stg_lp_d;
      pend_q   <= pend_d;
      wait_q   <= wait_d;
      cmd_q    <= cmd_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_DIV: rdata[DIV_W-1:0] = sh_div_q;
      A_ENA: begin
        rdata[EN_BIT] = sh_en_q;
        rdata[LP_BIT] = sh_lp_q;
      end
      A_CMD: begin
        rdata = cmd_q;
        rdata[START_BIT] = pend_q;
      end
      default: rdata = '0;
    endcase
  end

  // R6
  defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && wait_q && data_busy |=> pend_q);

  // R9
  staged_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pend_q) && pend_q |-> $stable(stg_div) && $stable(stg_en) && $stable(stg_lp));
endmodule

// File: rtl/cardclk_div.sv
module cardclk_div #(
  parameter int DIV_W    = 8,
  parameter int IDLE_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply,
  input  logic [DIV_W-1:0] stg_div,
  input  logic             stg_en,
  input  logic             stg_lp,
  input  logic             bus_req,
  output logic             div_q,
  output logic             run,
  output logic             bypass,
  output logic             clk_low
);
  localparam int IDLE_W = $clog2(IDLE_CYC + 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_CYC - 1);

  logic [DIV_W-1:0]  act_div_q, act_div_d, cnt_q, cnt_d;
  logic              act_en_q, act_en_d, act_lp_q, act_lp_d;
  logic              div_d, stop_q, stop_d, tc, fall;
  logic [IDLE_W-1:0] idle_q, idle_d;

  always_comb begin
    bypass  = (act_div_q == '0);
    run     = act_en_q && !stop_q;
    clk_low = !div_q;
    tc      = ((cnt_q + 1'b1) == act_div_q);
    fall    = bypass ? run : (run && div_q && tc);

    act_div_d = act_div_q;
    act_en_d  = act_en_q;
    act_lp_d  = act_lp_q;
    cnt_d     = '0;
    div_d     = div_q;
    stop_d    = stop_q;
    idle_d    = idle_q;

    if (apply) begin
      act_div_d = stg_div;
      act_en_d  = stg_en;
      act_lp_d  = stg_lp;
      div_d     = 1'b0;
      stop_d    = 1'b0;
      idle_d    = '0;
    end else begin
      if (run && !bypass) begin
        if (tc) div_d = !div_q;
        else    cnt_d = cnt_q + 1'b1;
      end
      if (bus_req) begin
        stop_d = 1'b0;
        idle_d = '0;
      end else if (act_lp_q && fall) begin
        if (idle_q == IDLE_LAST) begin
          stop_d = 1'b1;
          idle_d = '0;
        end else begin
          idle_d = idle_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div_q <= '0;
      act_en_q  <= 1'b0;
      act_lp_q  <= 1'b0;
      cnt_q     <= '0;
      div_q     <= 1'b0;
      stop_q    <= 1'b0;
      idle_q    <= '0;
    end else begin
      act_div_q <= act_div_d;
      act_en_q  <= act_en_d;
      act_lp_q  <= act_lp_d;
      cnt_q     <= cnt_d;
      div_q     <= div_d;
      stop_q    <= stop_d;
      idle_q    <= idle_d;
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass |-> cnt_q < act_div_q);

  // R10
  apply_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> !div_q);

  // R8
  lp_stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> !div_q);
endmodule

// File: rtl/cardclk_gate.sv
module cardclk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bypass,
  input  logic div_q,
  output logic card_clk
);
  logic byp_n_q, gate_n_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_n_q  <= 1'b0;
      gate_n_q <= 1'b0;
    end else begin
      byp_n_q  <= bypass;
      gate_n_q <= run;
    end
  end

  always_comb card_clk = byp_n_q ? (clk & gate_n_q) : div_q;

  // R7
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !$past(run) && !byp_n_q |-> !div_q);
endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
  import cardclk_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int IDLE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              data_busy,
  input  logic              bus_req,
  output logic              card_clk
);
  logic [1:0]       rst_sync_q;
  logic             srst_n;
  logic             apply, clk_low, div_q, run, bypass;
  logic [DIV_W-1:0] stg_div;
  logic             stg_en, stg_lp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  cardclk_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(srst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .data_busy(data_busy),
    .clk_low(clk_low), .apply(apply), .stg_div(stg_div),
    .stg_en(stg_en), .stg_lp(stg_lp)
  );

  cardclk_div #(.DIV_W(DIV_W), .IDLE_CYC(IDLE_CYC)) u_div (
    .clk(clk), .rst_n(srst_n), .apply(apply), .stg_div(stg_div),
    .stg_en(stg_en), .stg_lp(stg_lp), .bus_req(bus_req),
    .div_q(div_q), .run(run), .bypass(bypass), .clk_low(clk_low)
  );

  cardclk_gate u_gate (
    .clk(clk), .rst_n(srst_n), .run(run), .bypass(bypass),
    .div_q(div_q), .card_clk(card_clk)
  );
endmodule

// File: tb/sim_cardclk_gen.sv
module sim_cardclk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        data_busy = 1'b0;
  logic        bus_req = 1'b0;
  logic        card_clk;

  int compared = 0;
  int mismatched = 0;
  int edges = 0;
  bit done = 1'b0;

  localparam int W = 240;
  localparam logic [31:0] UPD  = 32'h8020_0000;
  localparam logic [31:0] WAITB = 32'h0000_2000;
  // {en, div}
  localparam logic [8:0] VEC [0:6] = '{9'h101, 9'h102, 9'h103, 9'h105, 9'h100, 9'h104, 9'h002};

  cardclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .data_busy(data_busy),
    .bus_req(bus_req), .card_clk(card_clk)
  );

  always #2.5 clk = ~clk;
  always @(posedge card_clk) edges++;

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_clear(input string tag);
    logic [31:0] v;
    int n = 0;
    rd(2'd2, v);
    while (v[31] && n < 1000) begin
      rd(2'd2, v);
      n++;
    end
    check(tag, int'(v[31]), 0);
  endtask

  task automatic update(input logic [31:0] extra, input string tag);
    wr(2'd2, UPD | extra);
    wait_clear(tag);
  endtask

  task automatic measure(input int cyc, output int n);
    int e0;
    @(negedge clk);
    e0 = edges;
    repeat (cyc) @(negedge clk);
    n = edges - e0;
  endtask

  initial begin
    int cnt;
    repeat (50000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n, e0, exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 reset state
    rd(2'd0, v); check("R3 div reg", int'(v), 0);
    rd(2'd1, v); check("R3 gate reg", int'(v), 0);
    rd(2'd2, v); check("R3 start bit", int'(v[31]), 0);
    measure(100, n); check("R3 clock idle", n, 0);
    check("R3 clock level", int'(card_clk), 0);

    // R1 R2 R7 vector table
    for (int i = 0; i < 7; i++) begin
      wr(2'd0, 32'(VEC[i][7:0]));
      wr(2'd1, {31'd0, VEC[i][8]});
      update(32'd0, "R5 start clears");
      repeat (4) @(negedge clk);
      measure(W, n);
      if (!VEC[i][8]) exp = 0;
      else if (VEC[i][7:0] == 0) exp = W;
      else exp = W / (2 * int'(VEC[i][7:0]));
      check(VEC[i][8] ? (VEC[i][7:0] == 0 ? "R2 bypass rate" : "R1 divided rate") : "R7 disabled", n, exp);
    end
    check("R7 level low", int'(card_clk), 0);

    // running at divide 2
    wr(2'd0, 32'd2); wr(2'd1, 32'd1);
    update(32'd0, "R5 start clears");
    // R4 held write
    wr(2'd0, 32'd5);
    measure(W, n); check("R4 no early effect", n, 60);
    rd(2'd0, v); check("R4 div readback", int'(v), 5);
    wr(2'd1, 32'h0001_0001);
    rd(2'd1, v); check("R4 gate readback", int'(v), 32'h0001_0001);
    wr(2'd1, 32'h0000_0001);
    // R5 command without update-only bit ignored
    wr(2'd2, 32'h8000_0000);
    rd(2'd2, v); check("R5 plain cmd ignored", int'(v[31]), 0);
    measure(W, n); check("R5 plain cmd rate", n, 60);

    // R6 deferral and R9 held writes
    data_busy = 1'b1;
    wr(2'd2, UPD | WAITB);
    repeat (20) @(negedge clk);
    rd(2'd2, v); check("R6 start held", int'(v[31]), 1);
    measure(W, n); check("R6 old rate while busy", n, 60);
    wr(2'd0, 32'd3);
    @(negedge clk);
    data_busy = 1'b0;
    wait_clear("R6 released");
    repeat (4) @(negedge clk);
    measure(W, n); check("R9 staged value used", n, 24);
    rd(2'd0, v); check("R9 new write kept", int'(v), 3);
    update(32'd0, "R9 next update");
    measure(W, n); check("R9 next update rate", n, 40);
    // R6 without wait bit, busy ignored
    wr(2'd0, 32'd1);
    data_busy = 1'b1;
    update(32'd0, "R6 no wait clears");
    measure(W, n); check("R6 busy ignored rate", n, 120);
    data_busy = 1'b0;

    // R8 low power
    wr(2'd1, 32'd0);
    update(32'd0, "R8 stop first");
    repeat (4) @(negedge clk);
    wr(2'd1, 32'h0001_0001);
    @(negedge clk);
    e0 = edges;
    update(32'd0, "R8 lp update");
    repeat (100) @(negedge clk);
    check("R8 idle pulses", edges - e0, 8);
    measure(100, n); check("R8 parked", n, 0);
    check("R8 parked low", int'(card_clk), 0);
    e0 = edges;
    bus_req = 1'b1;
    @(negedge clk);
    bus_req = 1'b0;
    repeat (100) @(negedge clk);
    check("R8 wake pulses", edges - e0, 8);
    bus_req = 1'b1;
    repeat (4) @(negedge clk);
    measure(W, n); check("R8 held request rate", n, 120);
    bus_req = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule